// File: doc/BRIEF.md
# Frame-End Alignment Character Replacer

This block sits in the data-phase path of a JESD204B transmit lane, ahead of scrambling and 8b/10b encoding. It receives one octet per valid cycle with two markers: one for the last octet of a frame and one for the last octet of a multiframe. It decides whether that end octet should be sent as an alignment control character, so that the receiver can monitor frame alignment. Each outgoing octet carries a flag that tells the encoder to emit a control symbol instead of a data symbol.

The rule depends on the scrambling setting. With scrambling off, a frame-end octet is replaced when it repeats the end octet of the previous frame. With scrambling on, the block compares the octet with two fixed values instead. A multiframe end is replaced by the lane-alignment character K28.3, with octet value 0x7C. Any other frame end is replaced by the frame-alignment character K28.7, with octet value 0xFC. Outside the data phase the stream passes through unchanged, and the stored previous-frame octet is forgotten.

Top module: `fcr_frame_end_replacer`

## Requirements
- R1: Every input beat appears at the outputs exactly one clock later, with its valid flag, frame-end marker and multiframe-end marker kept aligned to the octet. An invalid beat never carries the control flag.
- R2: While `in_data_phase` is 0, no octet is replaced: `out_ctrl` is 0 and `out_octet` equals the input octet.
- R3: With `in_scr_en` = 0 in the data phase, a frame-end octet that is not a multiframe end is replaced by K28.7 (`out_ctrl` = 1, `out_octet` = 0xFC) when it equals the end octet of the previous frame.
- R4: With `in_scr_en` = 0 in the data phase, a multiframe-end octet that equals the end octet of the previous frame is replaced by K28.3 (`out_ctrl` = 1, `out_octet` = 0x7C). A multiframe end is always marked with frame-end as well.
- R5: With scrambling off, the comparison uses the original input octet of the previous frame end, even when that octet was itself replaced. A run of equal frame-end octets is therefore replaced from the second one onward.
- R6: Each time the data phase is entered, the stored previous octet is invalid, so the first frame end that follows is never replaced for repetition.
- R7: With `in_scr_en` = 1 in the data phase, a multiframe-end octet equal to 0x7C is flagged as K28.3 (`out_octet` = 0x7C). A multiframe-end octet of 0xFC is not replaced.
- R8: With `in_scr_en` = 1 in the data phase, a frame-end octet that is not a multiframe end and equals 0xFC is flagged as K28.7. A value of 0x7C there, or a repeat of the previous end octet, is not replaced.
- R9: Octets that are not frame ends are never replaced, whatever their value.
- R10: While `rst_n` is low, `out_valid` and `out_ctrl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input octet valid |
| in_octet | input | 8 | Input octet |
| in_frame_end | input | 1 | Octet is the last of a frame |
| in_mf_end | input | 1 | Octet is the last of a multiframe |
| in_data_phase | input | 1 | Link is in the data transmission phase |
| in_scr_en | input | 1 | Scrambling is enabled on the link |
| out_valid | output | 1 | Output octet valid |
| out_octet | output | 8 | Output octet, or the control code when flagged |
| out_ctrl | output | 1 | Octet is to be encoded as a control character |
| out_frame_end | output | 1 | Delayed frame-end marker |
| out_mf_end | output | 1 | Delayed multiframe-end marker |

## Verification
The assertions assume that a valid multiframe-end marker always comes with the frame-end marker. They also assume that the scrambling setting does not change in the middle of a data phase. The stimulus builds every frame sequence so that the multiframe marker sits on the frame-end octet of the last frame. The scrambling setting changes only while the data phase is low. Gaps with `in_valid` low are placed between frame ends so that they do not interfere with these rules.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int unsigned OCTET_W = 8;
  typedef logic [OCTET_W-1:0] octet_t;

  // Control-character octet values: K28.3 (lane alignment), K28.7 (frame alignment)
  localparam octet_t K_LANE_ALIGN  = octet_t'(8'h7C);
  localparam octet_t K_FRAME_ALIGN = octet_t'(8'hFC);

  typedef struct packed {
    logic   valid;
    octet_t data;
    logic   ctrl;
    logic   fe;
    logic   mfe;
  } beat_t;

  // Fixed-value rule used while scrambling is on
  function automatic logic fixed_hit(input logic mfe, input octet_t d);
    return mfe ? (d == K_LANE_ALIGN) : (d == K_FRAME_ALIGN);
  endfunction

  // Repetition rule used while scrambling is off
  function automatic logic repeat_hit(input logic ok, input octet_t prev, input octet_t d);
    return ok && (d == prev);
  endfunction

  function automatic octet_t ctrl_code(input logic mfe);
    return mfe ? K_LANE_ALIGN : K_FRAME_ALIGN;
  endfunction
endpackage

// File: rtl/fcr_prev_store.sv
module fcr_prev_store
  import fcr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   phase,
  input  logic   take,
  input  octet_t octet_in,
  output octet_t prev_q,
  output logic   prev_ok_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
    end else if (!phase) begin
      prev_ok_q <= 1'b0;
    end else if (take) begin
      prev_q    <= octet_in;
      prev_ok_q <= 1'b1;
    end
  end

  AST_PREV_FORGOTTEN: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |=> !prev_ok_q); // R6

  AST_PREV_IS_ORIGINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && take) |=> (prev_ok_q && prev_q == $past(octet_in))); // R5
endmodule

// File: rtl/fcr_match.sv
module fcr_match
  import fcr_pkg::*;
(
  input  logic   valid,
  input  octet_t octet_in,
  input  logic   fe,
  input  logic   mfe,
  input  logic   phase,
  input  logic   scr_en,
  input  octet_t prev,
  input  logic   prev_ok,
  output logic   hit_repeat,
  output logic   hit_fixed,
  output logic   replace,
  output octet_t code
);
  logic at_end;

  always_comb begin
    at_end     = valid && phase && fe;
    hit_repeat = at_end && !scr_en && repeat_hit(prev_ok, prev, octet_in);
    hit_fixed  = at_end &&  scr_en && fixed_hit(mfe, octet_in);
    replace    = hit_repeat || hit_fixed;
    code       = replace ? ctrl_code(mfe) : octet_in;
  end
endmodule

// File: rtl/fcr_out_reg.sv
module fcr_out_reg
  import fcr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  beat_t beat_d,
  output beat_t beat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    beat_d.valid |=> beat_q.valid); // R1

  AST_ONE_CYCLE_MARKERS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_d.valid |=> (beat_q.fe == $past(beat_d.fe) && beat_q.mfe == $past(beat_d.mfe))); // R1
endmodule

// File: rtl/fcr_frame_end_replacer.sv
module fcr_frame_end_replacer
  import fcr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [OCTET_W-1:0] in_octet,
  input  logic               in_frame_end,
  input  logic               in_mf_end,
  input  logic               in_data_phase,
  input  logic               in_scr_en,
  output logic               out_valid,
  output logic [OCTET_W-1:0] out_octet,
  output logic               out_ctrl,
  output logic               out_frame_end,
  output logic               out_mf_end
);
  octet_t prev_q;
  logic   prev_ok_q;
  logic   hit_repeat, hit_fixed, replace;
  octet_t code;
  beat_t  beat_d, beat_q;
  logic   take_end;

  assign take_end = in_valid && in_frame_end;

  fcr_prev_store u_prev (
    .clk(clk), .rst_n(rst_n), .phase(in_data_phase), .take(take_end),
    .octet_in(in_octet), .prev_q(prev_q), .prev_ok_q(prev_ok_q)
  );

  fcr_match u_match (
    .valid(in_valid), .octet_in(in_octet), .fe(in_frame_end), .mfe(in_mf_end),
    .phase(in_data_phase), .scr_en(in_scr_en), .prev(prev_q), .prev_ok(prev_ok_q),
    .hit_repeat(hit_repeat), .hit_fixed(hit_fixed), .replace(replace), .code(code)
  );

  always_comb begin
    beat_d.valid = in_valid;
    beat_d.data  = code;
    beat_d.ctrl  = replace;
    beat_d.fe    = in_frame_end;
    beat_d.mfe   = in_mf_end;
  end

  fcr_out_reg u_out (.clk(clk), .rst_n(rst_n), .beat_d(beat_d), .beat_q(beat_q));

  assign out_valid     = beat_q.valid;
  assign out_octet     = beat_q.data;
  assign out_ctrl      = beat_q.ctrl;
  assign out_frame_end = beat_q.fe;
  assign out_mf_end    = beat_q.mfe;

  AST_MF_HAS_FE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mf_end) |-> in_frame_end); // R4

  AST_RULES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_repeat && hit_fixed)); // R7

  AST_IDLE_NO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_ctrl); // R1

  AST_CTRL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    out_ctrl |-> out_frame_end); // R9

  AST_CTRL_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_ctrl |-> $past(in_data_phase)); // R2

  AST_CTRL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_ctrl |-> (out_octet == (out_mf_end ? K_LANE_ALIGN : K_FRAME_ALIGN))); // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> (!out_valid && !out_ctrl)); // R10
endmodule

// File: tb/fcr_frame_end_replacer_bench.sv
module fcr_frame_end_replacer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_octet = 8'h00;
  logic       in_frame_end = 1'b0;
  logic       in_mf_end = 1'b0;
  logic       in_data_phase = 1'b0;
  logic       in_scr_en = 1'b0;
  logic       out_valid, out_ctrl, out_frame_end, out_mf_end;
  logic [7:0] out_octet;

  always #2 clk = ~clk; // 250 MHz

  fcr_frame_end_replacer u_fcr_frame_end_replacer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_octet(in_octet),
    .in_frame_end(in_frame_end), .in_mf_end(in_mf_end),
    .in_data_phase(in_data_phase), .in_scr_en(in_scr_en),
    .out_valid(out_valid), .out_octet(out_octet), .out_ctrl(out_ctrl),
    .out_frame_end(out_frame_end), .out_mf_end(out_mf_end)
  );

  typedef struct {
    logic       v;
    logic [7:0] d;
    logic       c;
    logic       fe;
    logic       mf;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  logic [7:0] m_prev = 8'h00;
  logic       m_ok = 1'b0;
  bit         done = 1'b0;

  // Driver: one beat per cycle, expected result from the requirements
  task automatic drive(input logic v, input logic [7:0] d, input logic fe, input logic mf,
                       input logic ph, input logic scr, input string tag);
    exp_t e;
    logic repl;
    @(negedge clk);
    in_valid = v; in_octet = d; in_frame_end = fe; in_mf_end = mf;
    in_data_phase = ph; in_scr_en = scr;
    repl = 1'b0;
    if (v && ph && fe) begin
      if (scr) repl = mf ? (d == 8'h7C) : (d == 8'hFC);
      else     repl = m_ok && (d == m_prev);
    end
    e.v = v; e.c = repl; e.fe = fe; e.mf = mf; e.tag = tag;
    e.d = repl ? (mf ? 8'h7C : 8'hFC) : d;
    exp_q.push_back(e);
    if (!ph) m_ok = 1'b0;
    else if (v && fe) begin m_prev = d; m_ok = 1'b1; end
  endtask

  // Monitor: compares each output beat one cycle after its input
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (out_valid !== e.v || (e.v && (out_octet !== e.d || out_ctrl !== e.c ||
            out_frame_end !== e.fe || out_mf_end !== e.mf)) || (!e.v && out_ctrl !== 1'b0)) begin
          n_bad++;
          $display("FAIL %s: got v=%b d=%h c=%b fe=%b mf=%b, want v=%b d=%h c=%b fe=%b mf=%b",
                   e.tag, out_valid, out_octet, out_ctrl, out_frame_end, out_mf_end,
                   e.v, e.d, e.c, e.fe, e.mf);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || out_ctrl !== 1'b0) begin // R10 reset state
      n_bad++;
      $display("FAIL R10: got v=%b c=%b, want v=0 c=0", out_valid, out_ctrl);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2: repeats outside the data phase pass through
    drive(1, 8'h11, 1, 0, 0, 0, "R2");
    drive(1, 8'h11, 1, 0, 0, 0, "R2");
    drive(1, 8'h7C, 1, 1, 0, 1, "R2");
    drive(1, 8'hFC, 1, 0, 0, 1, "R2");

    // Data phase, scrambling off
    drive(1, 8'h11, 1, 0, 1, 0, "R6");  // first frame end: kept
    drive(1, 8'h11, 0, 0, 1, 0, "R9");
    drive(1, 8'h11, 1, 0, 1, 0, "R3");  // repeat -> K28.7
    drive(0, 8'h11, 1, 0, 1, 0, "R1");  // gap
    drive(1, 8'h11, 1, 0, 1, 0, "R5");  // compared with original octet
    drive(1, 8'h11, 1, 1, 1, 0, "R4");  // repeat at multiframe end -> K28.3
    drive(1, 8'h22, 1, 0, 1, 0, "R3");  // differs: kept
    drive(1, 8'h33, 0, 0, 1, 0, "R9");
    drive(1, 8'h33, 0, 0, 1, 0, "R9");
    drive(1, 8'h22, 1, 1, 1, 0, "R4");

    // Leave and re-enter: memory forgotten
    drive(0, 8'h00, 0, 0, 0, 0, "R1");
    drive(1, 8'h22, 1, 0, 1, 0, "R6");
    drive(1, 8'h22, 1, 0, 1, 0, "R3");

    // Scrambling on (changed while phase is low)
    drive(0, 8'h00, 0, 0, 0, 1, "R1");
    drive(1, 8'h7C, 1, 1, 1, 1, "R7");
    drive(1, 8'hFC, 1, 1, 1, 1, "R7");
    drive(1, 8'hFC, 1, 0, 1, 1, "R8");
    drive(1, 8'h7C, 1, 0, 1, 1, "R8");
    drive(1, 8'h55, 1, 0, 1, 1, "R8");
    drive(1, 8'h55, 1, 0, 1, 1, "R8");
    drive(1, 8'hFC, 0, 0, 1, 1, "R9");
    drive(1, 8'h7C, 0, 0, 1, 1, "R9");

    // Longer streams: 2-octet frames, 4 frames per multiframe
    for (int s = 0; s < 2; s++) begin
      drive(0, 8'h00, 0, 0, 0, logic'(s), "R6");
      lf = 32'h1D2C_3B4A + s;
      for (int i = 0; i < 400; i++) begin
        logic [7:0] d;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        d = (lf[3:0] < 4'd6) ? ((lf[4]) ? 8'h7C : 8'hFC) : {5'b01000, lf[7:5]};
        drive(!(lf[9:8] == 2'b00 && (i % 2) == 0), d, (i % 2) == 1, (i % 8) == 7, 1,
              logic'(s), s ? "R8" : "R5");
      end
    end

    drive(0, 8'h00, 0, 0, 0, 0, "R1");
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule